// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of byte-wide configuration registers for a clock generator. Both bus lines are sampled with the block's own system clock. Start and stop conditions, the acknowledge bit and data shifting are all derived from those samples. The single SDA output is an open-drain enable: when it is high, the pad pulls the line low.

Register addressing is not supported. A write begins with the write address and two bytes whose values are discarded. Every byte after those two goes into the next register, starting at register 0. A read begins with the read address. The slave first sends the value of the count register and then sends registers from 0 upward until the host declines a byte.

Two register pairs update their live copies only when the second byte of the pair arrives. A transaction that stops between the two bytes therefore leaves both registers unchanged. The full register contents are presented in parallel to the logic that the block configures.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2, which is a write, and the address byte 0xD3, which is a read. It does not acknowledge any other address byte, and the transaction that follows has no effect on the registers.
- R2: In a write, the two bytes after the address are acknowledged and their values are discarded. Each following data byte is stored in register 0, then 1, 2 and so on in ascending order. Registers 6, 19 and 20 store whatever is written to them.
- R3: When the host stops after any complete data byte, every byte received before the stop is kept. A start condition in the middle of a transaction restarts the data index at register 0.
- R4: In a read, the first byte sent is the value of register 8. After it come registers 0, 1, 2 and so on, each sent MSB first, while the host acknowledges. A byte that the host does not acknowledge ends the read. A register index beyond the last register reads as 0xFF.
- R5: Registers 11 and 12 form one pair, and registers 13 and 14 form another. The lower register of a pair takes its new value only when the upper register of the same pair is written in the same transaction. If the transaction ends after the lower byte, both registers of that pair keep their previous values.
- R6: Register 7 always reads 0x21. Its upper three bits (001) are a vendor code and its lower five bits (00001) are a revision code. Writes to register 7 have no effect.
- R7: Register 8 holds the readback count and resets to 0x08. A write of 0x00 to register 8 is ignored.
- R8: A data byte aimed beyond register 20 is not acknowledged and is not stored.
- R9: After reset, every register reads 0x00 except register 7 (0x21) and register 8 (0x08), and the slave does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| regs_o | output | NUM_REGS*8 | All live registers; register i occupies bits [8i+7:8i] |

## Verification
The bench uses the default parameters: 21 registers, the count at register 8, the pairs at 11/12 and 13/14, and two synchronizer stages. Each bus phase lasts five system clocks, which leaves room for the synchronizer delay on every edge.

With only 21 registers, the random write lengths of 0 to 23 bytes regularly stop between the two bytes of a pair and also run past register 20. Random count values between 1 and 21 make reads anywhere from a single byte up to the whole register file. Directed transactions cover the following cases:
- a rejected address
- a count write of zero
- a restart in the middle of a write
- each pair split at its midpoint

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_ACK,
      ST_TX,
      ST_TXACK
   } link_st_t;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_s;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_ff[s] <= 1'b1;
               sda_ff[s] <= 1'b1;
            end else begin
               scl_ff[s] <= scl_ff[s-1];
               sda_ff[s] <= sda_ff[s-1];
            end
      end
   end

   assign scl_s = scl_ff[SYNC_STAGES-1];
   assign sda_s = sda_ff[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_link.sv
module cfg_link
   import cfg_pkg::*;
#(
   parameter int         NUM_REGS = 21,
   parameter int         IDX_W    = 6,
   parameter int         CNT_REG  = 8,
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_addr,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS + 2);
   localparam logic [IDX_W-1:0] CNT_W = IDX_W'(CNT_REG);
   localparam logic [IDX_W-1:0] TWO   = IDX_W'(2);

   link_st_t         state;
   logic [3:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [IDX_W-1:0] byte_idx, tx_idx;
   logic             is_rd, nack;

   assign rd_idx = (tx_idx == '0) ? CNT_W : tx_idx - 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_idx <= '0;
         tx_idx   <= '0;
         is_rd    <= 1'b0;
         nack     <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            byte_idx <= '0;
            tx_idx   <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           is_rd  <= shreg[0];
                           state  <= ST_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        if (byte_idx < TWO) begin
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                        end else if (byte_idx < LIMIT) begin
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                           wr_en   <= 1'b1;
                           wr_addr <= byte_idx - TWO;
                           wr_data <= shreg;
                        end else begin
                           state <= ST_IDLE;
                        end
                        if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (is_rd) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TXACK;
                        if (tx_idx != '1) tx_idx <= tx_idx + 1'b1;
                     end else begin
                        shreg   <= {shreg[6:0], 1'b0};
                        sda_oe  <= ~shreg[6];
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= ST_IDLE;
                     end else begin
                        shreg   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                        state   <= ST_TX;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end

   assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state == ST_ACK || state == ST_TX));
   assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && !start_det |=> state == ST_IDLE && !sda_oe);
   assert_start_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> state == ST_ADDR && byte_idx == '0);
   assert_no_drive_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
   parameter int         NUM_REGS  = 21,
   parameter int         IDX_W     = 6,
   parameter int         CNT_REG   = 8,
   parameter logic [7:0] CNT_RESET = 8'h08,
   parameter int         ID_REG    = 7,
   parameter logic [7:0] ID_VALUE  = 8'h21,
   parameter int         PAIR_A    = 11,
   parameter int         PAIR_B    = 13
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam logic [IDX_W-1:0] NREG_W = IDX_W'(NUM_REGS);
   localparam logic [IDX_W-1:0] CNT_W  = IDX_W'(CNT_REG);
   localparam logic [IDX_W-1:0] PA_W   = IDX_W'(PAIR_A);
   localparam logic [IDX_W-1:0] PB_W   = IDX_W'(PAIR_B);

   logic [7:0] stage_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                            stage_q <= '0;
      else if (wr_en && (wr_addr == PA_W || wr_addr == PB_W)) stage_q <= wr_data;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      if (g == ID_REG) begin : g_fixed
         assign regs_o[g*8 +: 8] = ID_VALUE;
      end else begin : g_store
         localparam bit         IS_CNT  = (g == CNT_REG);
         localparam bit         IS_PLO  = (g == PAIR_A) || (g == PAIR_B);
         localparam logic [7:0] RST_VAL = IS_CNT ? CNT_RESET : 8'h00;
         logic [7:0] q, nxt;
         logic       hit;
         always_comb begin
            if (IS_PLO) begin
               hit = wr_en && (wr_addr == MY_IDX + 1'b1);
               nxt = stage_q;
            end else begin
               hit = wr_en && (wr_addr == MY_IDX) && (!IS_CNT || wr_data != 8'h00);
               nxt = wr_data;
            end
         end
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)   q <= RST_VAL;
            else if (hit) q <= nxt;
         assign regs_o[g*8 +: 8] = q;
      end
   end

   assign rd_data = (rd_idx < NREG_W) ? regs_o[32'(rd_idx)*8 +: 8] : 8'hFF;

   assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr < NREG_W);
   assert_cnt_zero_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == CNT_W && wr_data == 8'h00 |=> $stable(regs_o[CNT_REG*8 +: 8]));
   assert_pair_lo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == PA_W |=> $stable(regs_o[PAIR_A*8 +: 8]));
   assert_id_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == IDX_W'(ID_REG) |=> $stable(regs_o[ID_REG*8 +: 8]));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
   parameter int         NUM_REGS    = 21,
   parameter int         CNT_REG     = 8,
   parameter logic [7:0] CNT_RESET   = 8'h08,
   parameter int         ID_REG      = 7,
   parameter logic [7:0] ID_VALUE    = 8'h21,
   parameter int         PAIR_A      = 11,
   parameter int         PAIR_B      = 13,
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int IDX_W = $clog2(NUM_REGS + 2) + 1;

   if (SYNC_STAGES < 2)                      begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (CNT_REG >= NUM_REGS || ID_REG >= NUM_REGS) begin : g_bad_idx $error("special register outside file"); end
   if (PAIR_A + 1 >= NUM_REGS || PAIR_B + 1 >= NUM_REGS) begin : g_bad_pair $error("pair outside file"); end
   if (CNT_RESET == 8'h00)                   begin : g_bad_cnt   $error("count reset must be nonzero"); end

   logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic             wr_en;
   logic [IDX_W-1:0] wr_addr, rd_idx;
   logic [7:0]       wr_data, rd_data;

   cfg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .scl_i, .sda_i, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
   );

   cfg_link #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_REG(CNT_REG), .DEV_ADDR(DEV_ADDR)) u_link (
      .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
      .rd_data, .rd_idx, .wr_en, .wr_addr, .wr_data, .sda_oe(sda_oe_o)
   );

   cfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_REG(CNT_REG), .CNT_RESET(CNT_RESET),
                 .ID_REG(ID_REG), .ID_VALUE(ID_VALUE), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_idx, .rd_data, .regs_o
   );
endmodule

// File: tb/cfg_serial_slave_tb_top.sv
module cfg_serial_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 21;
   localparam int Q          = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe, sda_line;
   logic [NREG*8-1:0] regs;
   int errors = 0, checks = 0;
   logic [7:0] mdl [NREG];
   logic [7:0] mstage;
   logic [7:0] wbuf [32];

   assign sda_line = m_sda & ~sda_oe;
   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_slave dut_i (
      .clk, .rst_n, .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe), .regs_o(regs)
   );

   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_byte(int k, logic [7:0] d);
      if (k == 7) ;
      else if (k == 8) begin if (d != 8'h00) mdl[8] = d; end
      else if (k == 11 || k == 13) mstage = d;
      else if (k == 12 || k == 14) begin mdl[k-1] = mstage; mdl[k] = d; end
      else mdl[k] = d;
   endtask

   task automatic check_regs(string tag);
      for (int i = 0; i < NREG; i++)
         chk($sformatf("%s reg%0d", tag, i), {24'h0, regs[i*8 +: 8]}, {24'h0, mdl[i]});
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
   endtask

   task automatic bit_out(logic v);
      m_sda = v; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic send(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
      ack = ~sda_line; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv(logic last, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
         v[i] = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
      end
      bit_out(last);
   endtask

   task automatic wr_head(string tag);
      logic ack;
      send(8'hD2, ack);                      chk({tag, " R1 write address ack"}, 32'(ack), 1);
      send(8'($urandom_range(0, 255)), ack); chk({tag, " R2 command ack"}, 32'(ack), 1);
      send(8'($urandom_range(0, 255)), ack); chk({tag, " R2 count ack"}, 32'(ack), 1);
   endtask

   task automatic wr_txn(int n, string tag);
      logic ack;
      bus_start();
      wr_head(tag);
      for (int k = 0; k < n; k++) begin
         send(wbuf[k], ack);
         chk($sformatf("%s R8 data ack idx%0d", tag, k), 32'(ack), 32'(k < NREG));
         if (k >= NREG) break;
         model_byte(k, wbuf[k]);
      end
      bus_stop();
      check_regs(tag);
   endtask

   task automatic rd_txn(string tag);
      logic ack;
      logic [7:0] v;
      int n;
      bus_start();
      send(8'hD3, ack); chk({tag, " R1 read address ack"}, 32'(ack), 1);
      n = int'(mdl[8]);
      recv(1'b0, v);    chk({tag, " R4 count byte"}, 32'(v), 32'(mdl[8]));
      for (int k = 0; k < n; k++) begin
         recv(k == n - 1, v);
         chk($sformatf("%s R4 read reg%0d", tag, k), 32'(v), (k < NREG) ? 32'(mdl[k]) : 32'hFF);
      end
      bus_stop();
   endtask

   initial begin
      tick(190000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic ack;
      void'($urandom(32'h5eed));
      for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
      mdl[7] = 8'h21; mdl[8] = 8'h08; mstage = 8'h00;
      tick(4);
      rst_n = 1'b1;
      tick(4);
      check_regs("R9 reset");
      chk("R9 sda released", 32'(sda_oe), 0);
      chk("R6 id value", 32'(regs[7*8 +: 8]), 32'h21);

      // full file plus one byte past the end; count reg gets 5
      for (int k = 0; k < 22; k++) wbuf[k] = 8'(k * 7 + 3);
      wbuf[8] = 8'h05;
      wr_txn(22, "R2 full write");
      chk("R6 id after write", 32'(regs[7*8 +: 8]), 32'h21);
      rd_txn("R4 readback");

      // pair A split at its midpoint
      for (int k = 0; k < 12; k++) wbuf[k] = 8'(8'hA0 + k);
      wbuf[8] = 8'h05;
      wr_txn(12, "R5 pair A split");
      chk("R5 pair A lower kept", 32'(regs[11*8 +: 8]), 32'(8'(11 * 7 + 3)));
      // pair A complete, pair B split
      for (int k = 0; k < 14; k++) wbuf[k] = 8'(8'hB0 + k);
      wbuf[8] = 8'h05;
      wr_txn(14, "R5 pair B split");
      chk("R5 pair A committed", 32'(regs[11*8 +: 8]), 32'hBB);
      chk("R5 pair B lower kept", 32'(regs[13*8 +: 8]), 32'(8'(13 * 7 + 3)));

      // count write of zero
      for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'hC0 + k);
      wbuf[8] = 8'h00;
      wr_txn(9, "R7 zero count");
      chk("R7 count kept", 32'(regs[8*8 +: 8]), 32'h05);

      // foreign address
      bus_start();
      send(8'hA4, ack); chk("R1 foreign address nack", 32'(ack), 0);
      send(8'h55, ack);
      send(8'h66, ack);
      bus_stop();
      check_regs("R1 foreign no effect");

      // restart mid-write
      bus_start();
      wr_head("R3 first");
      send(8'h3C, ack); model_byte(0, 8'h3C);
      send(8'h4D, ack); model_byte(1, 8'h4D);
      bus_start();
      wr_head("R3 second");
      send(8'hC3, ack); model_byte(0, 8'hC3);
      bus_stop();
      check_regs("R3 restart");
      chk("R3 restart reg0", 32'(regs[7:0]), 32'hC3);

      // random transactions
      for (int it = 0; it < 8; it++) begin
         int n;
         n = $urandom_range(0, 23);
         for (int k = 0; k < 32; k++) wbuf[k] = 8'($urandom_range(0, 255));
         wbuf[8] = 8'($urandom_range(1, NREG));
         wr_txn(n, $sformatf("R3 random write %0d", it));
         rd_txn($sformatf("R4 random read %0d", it));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule